// File: doc/BRIEF.md
# Stack-top cached integer executor

This block carries out one integer stack operation at a time for a word-oriented stack machine. Two pieces of state live inside it: the stack pointer, a word address of the current top entry, and a register copy of the word at that address. Because the top word is already in a register, each operation makes only the memory accesses it needs for the entries below the top, and every write that changes the top word also updates the register copy.

A controller presents an opcode together with a one-cycle start strobe while the block is idle. The block then drives a word-wide memory port through a fixed sequence of cycles and pulses done once the stack pointer, the top register and memory all hold their new values. The memory port has one read strobe and one write strobe. Read data comes back with a fixed delay: it is valid only in the cycle after the read strobe and is captured at the end of that cycle. Four binary operations are supported (add, subtract, bitwise and, bitwise or), plus duplicate, pop and exchange of the top two entries. Any other opcode is refused and flagged, and nothing is changed.

Top module: `stk_exec`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, done, err, mem_rd and mem_wr are low, sp_out equals SP_INIT and tos_out is zero.
- R2: Opcode 0x60 adds: the word at SP-1 plus the top word is written to memory at SP-1 and loaded into the top register, SP becomes SP-1 (for example 0xFFC03B becomes 0xFFC03A), and busy is high for exactly 3 cycles.
- R3: Opcode 0x64 subtracts with the schedule of R2. The result is the word at SP-1 minus the old top word, modulo 2^DW.
- R4: Opcodes 0x7E and 0x80 use the schedule of R2 and produce the bitwise AND and the bitwise OR of the two top words.
- R5: Opcode 0x59 increments SP, writes the top word to the new SP, keeps the top register unchanged and is busy for 1 cycle.
- R6: Opcode 0x57 decrements SP, reads the word at the new SP, loads it into the top register and is busy for 2 cycles.
- R7: Opcode 0x5F exchanges the words at SP and SP-1 in memory, loads the old SP-1 word into the top register, leaves SP unchanged and is busy for 4 cycles.
- R8: Read data is taken from mem_rdata only at the end of the cycle that follows the cycle with mem_rd high. mem_rd and mem_wr are never high together.
- R9: An opcode outside the seven above gives a done pulse with err high in the cycle after start is taken. SP, the top register and memory are left unchanged, and no memory strobe is raised.
- R10: A start strobe while busy is high is ignored. It causes no extra done and does not change the running operation's result. While busy is low, no memory strobe is raised.
- R11: done is a single-cycle pulse. The operations issue these counts of read and write strobes: binary ops 1 and 1, duplicate 0 and 1, pop 1 and 0, exchange 1 and 2.
- R12: When done is high, tos_out equals the memory word at address sp_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the operation in opcode; sampled only while idle |
| opcode | input | 8 | Operation code |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when an operation has completed |
| err | output | 1 | Set together with done when the opcode is not recognised |
| mem_addr | output | AW | Word address for the memory port |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid in the cycle after mem_rd |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| sp_out | output | AW | Current stack pointer |
| tos_out | output | DW | Cached top-of-stack word |

## Verification
The hardest case to reach from the ports is a design that captures read data one cycle early or one cycle late. A memory model that always returns the right word would hide this. The bench's memory therefore presents the addressed word only in the single cycle after the read strobe and drives a junk pattern in every other cycle, so any mistimed capture corrupts a result. A second hard case is a start strobe landing in the middle of an operation. The bench raises start with a different opcode during a running add and expects exactly one completion with the add's result.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam logic [7:0] OPC_ADD  = 8'h60;
    localparam logic [7:0] OPC_SUB  = 8'h64;
    localparam logic [7:0] OPC_AND  = 8'h7E;
    localparam logic [7:0] OPC_OR   = 8'h80;
    localparam logic [7:0] OPC_DUP  = 8'h59;
    localparam logic [7:0] OPC_POP  = 8'h57;
    localparam logic [7:0] OPC_SWAP = 8'h5F;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BIN_RD, ST_BIN_HOLD, ST_BIN_WB,
        ST_DUP_WR,
        ST_POP_RD, ST_POP_LD,
        ST_SWP_RD, ST_SWP_CAP, ST_SWP_HI, ST_SWP_LO
    } state_e;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_e;
    typedef enum logic [1:0] {ADR_BELOW, ADR_TOP, ADR_ABOVE} adr_e;
    typedef enum logic [1:0] {WD_ALU, WD_TOS, WD_MDR} wd_e;
    typedef enum logic [1:0] {TOS_KEEP, TOS_ALU, TOS_RD, TOS_H} tos_e;
    typedef enum logic [1:0] {H_KEEP, H_TOS, H_MDR} h_e;

    typedef struct packed {
        logic sp_dec;
        logic sp_inc;
        logic rd;
        logic wr;
        logic mdr_ld;
        adr_e adr;
        wd_e  wd;
        tos_e tos;
        h_e   hsel;
    } ctrl_t;

    function automatic state_e entry_state(input logic [7:0] op);
        case (op)
            OPC_ADD, OPC_SUB, OPC_AND, OPC_OR: return ST_BIN_RD;
            OPC_DUP:  return ST_DUP_WR;
            OPC_POP:  return ST_POP_RD;
            OPC_SWAP: return ST_SWP_RD;
            default:  return ST_IDLE;
        endcase
    endfunction

    function automatic alu_e alu_of(input logic [7:0] op);
        case (op)
            OPC_SUB: return ALU_SUB;
            OPC_AND: return ALU_AND;
            OPC_OR:  return ALU_OR;
            default: return ALU_ADD;
        endcase
    endfunction

endpackage

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
#(
    parameter int DW = 32
) (
    input  alu_e          op,
    input  logic [DW-1:0] below,
    input  logic [DW-1:0] top,
    output logic [DW-1:0] y
);
    always_comb begin
        case (op)
            ALU_SUB: y = below - top;
            ALU_AND: y = below & top;
            ALU_OR:  y = below | top;
            default: y = below + top;
        endcase
    end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] opcode,
    output ctrl_t      ctrl,
    output alu_e       alu_op,
    output logic       busy,
    output logic       done,
    output logic       err
);
    state_e state_q;
    alu_e   alu_q;
    logic   done_q, err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            alu_q   <= ALU_ADD;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    if (entry_state(opcode) == ST_IDLE) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                    end else begin
                        state_q <= entry_state(opcode);
                        alu_q   <= alu_of(opcode);
                    end
                end
                ST_BIN_RD:   state_q <= ST_BIN_HOLD;
                ST_BIN_HOLD: state_q <= ST_BIN_WB;
                ST_POP_RD:   state_q <= ST_POP_LD;
                ST_SWP_RD:   state_q <= ST_SWP_CAP;
                ST_SWP_CAP:  state_q <= ST_SWP_HI;
                ST_SWP_HI:   state_q <= ST_SWP_LO;
                default: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        ctrl = '{sp_dec: 1'b0, sp_inc: 1'b0, rd: 1'b0, wr: 1'b0, mdr_ld: 1'b0,
                 adr: ADR_TOP, wd: WD_TOS, tos: TOS_KEEP, hsel: H_KEEP};
        case (state_q)
            ST_BIN_RD:   begin ctrl.sp_dec = 1'b1; ctrl.rd = 1'b1; ctrl.adr = ADR_BELOW; end
            ST_BIN_HOLD: begin ctrl.hsel = H_TOS; ctrl.mdr_ld = 1'b1; end
            ST_BIN_WB:   begin ctrl.wr = 1'b1; ctrl.wd = WD_ALU; ctrl.tos = TOS_ALU; end
            ST_DUP_WR:   begin ctrl.sp_inc = 1'b1; ctrl.wr = 1'b1; ctrl.adr = ADR_ABOVE; end
            ST_POP_RD:   begin ctrl.sp_dec = 1'b1; ctrl.rd = 1'b1; ctrl.adr = ADR_BELOW; end
            ST_POP_LD:   ctrl.tos = TOS_RD;
            ST_SWP_RD:   begin ctrl.rd = 1'b1; ctrl.adr = ADR_BELOW; end
            ST_SWP_CAP:  ctrl.mdr_ld = 1'b1;
            ST_SWP_HI:   begin ctrl.wr = 1'b1; ctrl.wd = WD_MDR; ctrl.hsel = H_MDR; end
            ST_SWP_LO:   begin ctrl.wr = 1'b1; ctrl.adr = ADR_BELOW; ctrl.tos = TOS_H; end
            default: ;
        endcase
    end

    assign alu_op = alu_q;
    assign busy   = (state_q != ST_IDLE);
    assign done   = done_q;
    assign err    = err_q;
endmodule

// File: rtl/stk_exec.sv
module stk_exec
    import stk_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter logic [AW-1:0] SP_INIT = 16'h0040
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [7:0]    opcode,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] sp_out,
    output logic [DW-1:0] tos_out
);
    localparam logic [AW-1:0] ONE = AW'(1);

    ctrl_t         ctrl;
    alu_e          alu_op;
    logic [AW-1:0] sp_q;
    logic [DW-1:0] tos_q, h_q, mdr_q, alu_y;

    stk_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .ctrl(ctrl), .alu_op(alu_op), .busy(busy), .done(done), .err(err)
    );

    stk_alu #(.DW(DW)) u_alu (
        .op(alu_op), .below(mdr_q), .top(h_q), .y(alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q  <= SP_INIT;
            tos_q <= '0;
            h_q   <= '0;
            mdr_q <= '0;
        end else begin
            if (ctrl.sp_dec) sp_q <= sp_q - ONE;
            else if (ctrl.sp_inc) sp_q <= sp_q + ONE;
            if (ctrl.mdr_ld) mdr_q <= mem_rdata;
            case (ctrl.hsel)
                H_TOS:   h_q <= tos_q;
                H_MDR:   h_q <= mdr_q;
                default: ;
            endcase
            case (ctrl.tos)
                TOS_ALU: tos_q <= alu_y;
                TOS_RD:  tos_q <= mem_rdata;
                TOS_H:   tos_q <= h_q;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (ctrl.adr)
            ADR_BELOW: mem_addr = sp_q - ONE;
            ADR_ABOVE: mem_addr = sp_q + ONE;
            default:   mem_addr = sp_q;
        endcase
        case (ctrl.wd)
            WD_ALU:  mem_wdata = alu_y;
            WD_MDR:  mem_wdata = mdr_q;
            default: mem_wdata = tos_q;
        endcase
    end

    assign mem_rd  = ctrl.rd;
    assign mem_wr  = ctrl.wr;
    assign sp_out  = sp_q;
    assign tos_out = tos_q;
endmodule

// File: rtl/stk_exec_chk.sv
module stk_exec_chk #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter logic [AW-1:0] SP_INIT = 16'h0040
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] sp_out,
    input logic [DW-1:0] tos_out
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!busy && !done && !err && !mem_rd && !mem_wr && sp_out == SP_INIT && tos_out == '0));

    // R8
    rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd && !mem_wr));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done);

    // R9
    err_done_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> ($stable(sp_out) && $stable(tos_out)));

    // R2
    sp_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sp_out != $past(sp_out)) |->
            (sp_out == $past(sp_out) + AW'(1) || sp_out == $past(sp_out) - AW'(1)));
endmodule

bind stk_exec stk_exec_chk #(.AW(AW), .DW(DW), .SP_INIT(SP_INIT)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .err(err),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .sp_out(sp_out), .tos_out(tos_out)
);

// File: tb/stk_exec_tb.sv
module stk_exec_tb;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam logic [AW-1:0] SP0 = 16'h0040;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [7:0]    opcode = 8'h00;
    logic          busy, done, err, mem_rd, mem_wr;
    logic [AW-1:0] mem_addr, sp_out;
    logic [DW-1:0] mem_wdata, tos_out;
    logic [DW-1:0] mem_rdata = 32'hBAD0_0BAD;

    always #2 clk = ~clk;

    stk_exec #(.AW(AW), .DW(DW), .SP_INIT(SP0)) u_dut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .busy(busy), .done(done), .err(err),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .sp_out(sp_out), .tos_out(tos_out)
    );

    logic [DW-1:0] mem [256];
    logic [DW-1:0] ref_mem [256];

    // R8: data is presented only in the cycle after the read strobe
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem_rd ? mem[mem_addr[7:0]] : 32'hBAD0_0BAD;
    end

    typedef struct {
        string         tag;
        logic [AW-1:0] sp;
        logic [DW-1:0] tos;
        logic [DW-1:0] below;
        logic          err;
        int            cyc;
        int            rds;
        int            wrs;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_fail = 0;
    logic [AW-1:0] m_sp  = SP0;
    logic [DW-1:0] m_tos = '0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    int busy_cnt = 0, rd_cnt = 0, wr_cnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_cnt++;
            if (mem_rd) rd_cnt++;
            if (mem_wr) wr_cnt++;
            if (done) begin
                if (q.size() == 0) begin
                    chk("R10", "unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.tag, "sp", 32'(sp_out), 32'(e.sp));
                    chk(e.tag, "tos", tos_out, e.tos);
                    chk(e.tag, "err", 32'(err), 32'(e.err));
                    chk(e.tag, "below", mem[8'(sp_out - 16'd1)], e.below);
                    chk("R11", "busy cycles", 32'(busy_cnt), 32'(e.cyc));
                    chk("R11", "reads", 32'(rd_cnt), 32'(e.rds));
                    chk("R11", "writes", 32'(wr_cnt), 32'(e.wrs));
                    chk("R12", "top word", mem[sp_out[7:0]], tos_out);
                end
                busy_cnt = 0; rd_cnt = 0; wr_cnt = 0;
            end
        end
    end

    task automatic push_exp(input logic [7:0] op, input string tag);
        exp_t e;
        logic [DW-1:0] b, r;
        e.tag = tag; e.err = 1'b0;
        case (op)
            8'h60, 8'h64, 8'h7E, 8'h80: begin
                b = ref_mem[8'(m_sp - 16'd1)];
                r = (op == 8'h60) ? b + m_tos : (op == 8'h64) ? b - m_tos :
                    (op == 8'h7E) ? (b & m_tos) : (b | m_tos);
                m_sp = m_sp - 16'd1; ref_mem[m_sp[7:0]] = r; m_tos = r;
                e.cyc = 3; e.rds = 1; e.wrs = 1;
            end
            8'h59: begin
                m_sp = m_sp + 16'd1; ref_mem[m_sp[7:0]] = m_tos;
                e.cyc = 1; e.rds = 0; e.wrs = 1;
            end
            8'h57: begin
                m_sp = m_sp - 16'd1; m_tos = ref_mem[m_sp[7:0]];
                e.cyc = 2; e.rds = 1; e.wrs = 0;
            end
            8'h5F: begin
                b = ref_mem[8'(m_sp - 16'd1)];
                ref_mem[m_sp[7:0]] = b; ref_mem[8'(m_sp - 16'd1)] = m_tos; m_tos = b;
                e.cyc = 4; e.rds = 1; e.wrs = 2;
            end
            default: begin
                e.err = 1'b1; e.cyc = 0; e.rds = 0; e.wrs = 0;
            end
        endcase
        e.sp = m_sp; e.tos = m_tos; e.below = ref_mem[8'(m_sp - 16'd1)];
        q.push_back(e);
    endtask

    task automatic run_op(input logic [7:0] op, input string tag, input bit poke);
        push_exp(op, tag);
        @(negedge clk); start = 1'b1; opcode = op;
        @(negedge clk); start = 1'b0;
        if (poke && busy) begin
            start = 1'b1; opcode = 8'h59;   // R10: must be ignored
            @(negedge clk); start = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    bit timed_out = 1'b0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = (i >= 8'h20 && i < 8'h40) ? 32'h1357_0000 + 32'(i) * 32'h0102_0305 : '0;
            ref_mem[i] = mem[i];
        end
        fork
            begin
                repeat (4) @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                chk("R1", "sp", 32'(sp_out), 32'(SP0));
                chk("R1", "tos", tos_out, 32'd0);
                chk("R1", "busy/done/err", {29'd0, busy, done, err}, 32'd0);
                chk("R1", "strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
                run_op(8'h57, "R6", 1'b0);
                run_op(8'h57, "R6", 1'b0);
                run_op(8'h60, "R2", 1'b0);
                run_op(8'h57, "R6", 1'b0);
                run_op(8'h64, "R3", 1'b0);
                run_op(8'h57, "R6", 1'b0);
                run_op(8'h7E, "R4", 1'b0);
                run_op(8'h57, "R6", 1'b0);
                run_op(8'h80, "R4", 1'b0);
                run_op(8'h59, "R5", 1'b0);
                run_op(8'h5F, "R7", 1'b0);
                run_op(8'h00, "R9", 1'b0);
                run_op(8'hFF, "R9", 1'b0);
                run_op(8'h60, "R10", 1'b1);
                run_op(8'h57, "R6", 1'b0);
                run_op(8'h5F, "R7", 1'b0);
                run_op(8'h57, "R6", 1'b0);
                run_op(8'h64, "R3", 1'b0);
                run_op(8'h59, "R5", 1'b0);
                run_op(8'h59, "R5", 1'b0);
                run_op(8'h60, "R2", 1'b0);
                repeat (3) @(negedge clk);
                chk("R10", "pending results", 32'(q.size()), 32'd0);
                chk("R10", "sp after idle", 32'(sp_out), 32'(m_sp));
            end
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule